// File: doc/BRIEF.md
# Two-Wire Serial Clock Waveform Generator

This block times the serial clock of a two-wire bus master. A single packed waveform word sets a low-phase divisor, a high-phase divisor and a power-of-two prescaler exponent. Each clock phase lasts `divisor * 2^exponent + OFFSET` input clock cycles. The low and high phases take separate divisors, so the duty cycle can be asymmetric. With equal divisors the bus period is twice one phase, and the bus rate is the input clock divided by that period. Software works out the divisor values, usually for a bus rate between 100 kHz and 400 kHz.

The generator runs only while `enable` is high. When it is disabled, the clock output is released (high), the counters are cleared and the waveform word passes straight through to the active settings. Once running, a new waveform word is held in a shadow register. It becomes active only at the next phase boundary, so a phase already under way is never cut short or stretched. The bit-level master logic uses four one-cycle strobes: the start of each phase, and the midpoint of each phase. The high midpoint is used to sample data and the low midpoint to change data.

Top module: `sclwave_gen`

## Requirements
- R1: After reset, and while `enable` is low, `scl_o` is 1 and all four strobes are 0.
- R2: Each low phase lasts `lo_div * 2^e + OFFSET` cycles. `lo_div` is `cfg_wdata[7:0]` and `e` is the effective exponent.
- R3: Each high phase lasts `hi_div * 2^e + OFFSET` cycles, with `hi_div` taken from `cfg_wdata[15:8]`. The two divisors are independent.
- R4: The exponent field is `cfg_wdata[18:16]`. A value above `EXP_MAX` (default 5) is treated as `EXP_MAX`.
- R5: In the cycle after `enable` is first sampled high, `scl_o` goes low and a full low phase begins.
- R6: `lo_start_o` is 1 in the first cycle of every low phase, and `hi_start_o` is 1 in the first cycle of every high phase. Neither is 1 in any other cycle.
- R7: `lo_mid_o` or `hi_mid_o` is 1 at cycle index `floor(L/2)` of a low or high phase of length `L`, where index 0 is the phase's first cycle. It is 0 at every other index.
- R8: A waveform write made during a phase leaves that phase's length unchanged. The phases after the next boundary use the new word.
- R9: In the cycle after `enable` is sampled low, `scl_o` is 1 and all strobes stop. Enabling again restarts with a full low phase.
- R10: A divisor of zero gives a phase of exactly `OFFSET` cycles (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator |
| cfg_we | input | 1 | Write strobe for the waveform word |
| cfg_wdata | input | 16+EXP_W | Waveform word: exponent [18:16], high divisor [15:8], low divisor [7:0] |
| scl_o | output | 1 | Serial clock level (1 = released) |
| lo_start_o | output | 1 | First cycle of a low phase |
| hi_start_o | output | 1 | First cycle of a high phase |
| lo_mid_o | output | 1 | Midpoint cycle of a low phase |
| hi_mid_o | output | 1 | Midpoint cycle of a high phase |

## Verification
The phase counter, the phase flag and the active settings are visible only through the lengths of the `scl_o` phases and the positions of the strobes.

- A wrong counter or a badly loaded divisor shows up at the first phase boundary as a low or high run of the wrong length.
- A shadow word committed too early changes the length of the phase in which it was written.
- A missed clamp stretches a phase by a power of two.

The bench times every phase cycle by cycle and checks each strobe at each index, so any such error is reported within one phase.

// File: rtl/sclwave_pkg.sv
package sclwave_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Cycles in one phase: divisor scaled by the prescaler, plus fixed overhead.
  function automatic int unsigned phase_cycles(input int unsigned div,
                                               input int unsigned expo,
                                               input int unsigned off);
    return (div << expo) + off;
  endfunction

  // Limit a programmed exponent to the largest one the divider supports.
  function automatic int unsigned clamp_exp(input int unsigned expo,
                                            input int unsigned emax);
    return (expo > emax) ? emax : expo;
  endfunction

endpackage

// File: rtl/sclwave_cfg.sv
module sclwave_cfg #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 5,
  localparam int CFG_W  = 2 * DIV_W + EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             load,
  output logic [DIV_W-1:0] act_lo,
  output logic [DIV_W-1:0] act_hi,
  output logic [EXP_W-1:0] act_exp
);
  import sclwave_pkg::*;

  logic [DIV_W-1:0] pend_lo, pend_hi;
  logic [EXP_W-1:0] pend_exp, wr_exp;

  // Clamp on entry so the active exponent is always legal.
  always_comb
    wr_exp = EXP_W'(clamp_exp(32'(wdata[CFG_W-1:2*DIV_W]), EXP_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lo  <= '0;
      pend_hi  <= '0;
      pend_exp <= '0;
    end else if (we) begin
      pend_lo  <= wdata[DIV_W-1:0];
      pend_hi  <= wdata[2*DIV_W-1:DIV_W];
      pend_exp <= wr_exp;
    end
  end

  // Commit the shadow word only when the timer reports a boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo  <= '0;
      act_hi  <= '0;
      act_exp <= '0;
    end else if (load) begin
      act_lo  <= pend_lo;
      act_hi  <= pend_hi;
      act_exp <= pend_exp;
    end
  end

  p_exp_clamped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_exp) <= EXP_MAX);

  p_hold_between_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(act_lo) && $stable(act_hi) && $stable(act_exp));

endmodule

// File: rtl/sclwave_timer.sv
module sclwave_timer #(
  parameter int DIV_W  = 8,
  parameter int EXP_W  = 3,
  parameter int OFFSET = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  act_lo,
  input  logic [DIV_W-1:0]  act_hi,
  input  logic [EXP_W-1:0]  act_exp,
  output logic              running,
  output sclwave_pkg::phase_e phase,
  output logic [LEN_W-1:0]  cnt,
  output logic [LEN_W-1:0]  len,
  output logic              load
);
  import sclwave_pkg::*;

  logic [DIV_W-1:0] cur_div;
  logic             last;

  always_comb begin
    cur_div = (phase == PH_HIGH) ? act_hi : act_lo;
    len     = LEN_W'(phase_cycles(32'(cur_div), 32'(act_exp), OFFSET));
    last    = running && (cnt == len - LEN_W'(1));
    load    = !enable || !running || last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= PH_LOW;
      cnt     <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      phase   <= PH_LOW;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      phase   <= PH_LOW;
      cnt     <= '0;
    end else if (last) begin
      phase   <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
      cnt     <= '0;
    end else begin
      cnt     <= cnt + LEN_W'(1);
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt < len);

  p_idle_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> cnt == '0 && phase == PH_LOW);

endmodule

// File: rtl/sclwave_strobes.sv
module sclwave_strobes #(
  parameter int LEN_W = 16
) (
  input  logic                running,
  input  sclwave_pkg::phase_e phase,
  input  logic [LEN_W-1:0]    cnt,
  input  logic [LEN_W-1:0]    len,
  output logic                scl,
  output logic                lo_start,
  output logic                hi_start,
  output logic                lo_mid,
  output logic                hi_mid
);
  import sclwave_pkg::*;

  logic at_start, at_mid;

  always_comb begin
    at_start = running && (cnt == '0);
    at_mid   = running && (cnt == (len >> 1));
    scl      = !running || (phase == PH_HIGH);
    lo_start = at_start && (phase == PH_LOW);
    hi_start = at_start && (phase == PH_HIGH);
    lo_mid   = at_mid && (phase == PH_LOW);
    hi_mid   = at_mid && (phase == PH_HIGH);
  end

  always_comb begin
    p_mid_onehot_r7: assert ($onehot0({lo_mid, hi_mid}));
  end

endmodule

// File: rtl/sclwave_gen.sv
module sclwave_gen #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 5,
  parameter int OFFSET  = 4,
  localparam int CFG_W  = 2 * DIV_W + EXP_W,
  localparam int LEN_W  = DIV_W + EXP_MAX + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             scl_o,
  output logic             lo_start_o,
  output logic             hi_start_o,
  output logic             lo_mid_o,
  output logic             hi_mid_o
);
  import sclwave_pkg::*;

  logic [DIV_W-1:0] act_lo, act_hi;
  logic [EXP_W-1:0] act_exp;
  logic             running, load;
  phase_e           phase;
  logic [LEN_W-1:0] cnt, len;

  sclwave_cfg #(.DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .load(load),
    .act_lo(act_lo), .act_hi(act_hi), .act_exp(act_exp)
  );

  sclwave_timer #(.DIV_W(DIV_W), .EXP_W(EXP_W), .OFFSET(OFFSET), .LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .act_lo(act_lo), .act_hi(act_hi), .act_exp(act_exp),
    .running(running), .phase(phase), .cnt(cnt), .len(len), .load(load)
  );

  sclwave_strobes #(.LEN_W(LEN_W)) u_strobes (
    .running(running), .phase(phase), .cnt(cnt), .len(len),
    .scl(scl_o), .lo_start(lo_start_o), .hi_start(hi_start_o),
    .lo_mid(lo_mid_o), .hi_mid(hi_mid_o)
  );

  p_disable_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> scl_o && !lo_start_o && !hi_start_o && !lo_mid_o && !hi_mid_o);

  p_enable_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !running |=> !scl_o && lo_start_o);

  p_fall_has_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> lo_start_o);

  p_rise_has_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) && $past(enable) |-> hi_start_o);

  p_starts_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_start_o && hi_start_o));

endmodule

// File: tb/sclwave_gen_tb.sv
module sclwave_gen_tb;
  localparam int OFFSET  = 4;
  localparam int EXP_MAX = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic        scl_o, lo_start_o, hi_start_o, lo_mid_o, hi_mid_o;

  int checks = 0;
  int failures = 0;
  int wr_at = -1;
  logic [18:0] wr_val = '0;

  always #2 clk = ~clk;

  sclwave_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .scl_o(scl_o), .lo_start_o(lo_start_o),
    .hi_start_o(hi_start_o), .lo_mid_o(lo_mid_o), .hi_mid_o(hi_mid_o)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk_cfg(input int e, input int hi, input int lo);
    return {e[2:0], hi[7:0], lo[7:0]};
  endfunction

  // Expected phase length, restated as repeated doubling.
  function automatic int exp_len(input int div, input int e);
    int r = div;
    int eff = (e > EXP_MAX) ? EXP_MAX : e;
    for (int k = 0; k < eff; k++) r = r * 2;
    return r + OFFSET;
  endfunction

  // Called at the negedge of a phase's first cycle; returns at the negedge
  // of the next phase's first cycle.
  task automatic watch_phase(input logic lvl, input int len, input string req);
    int idx = 0;
    while (scl_o == lvl && idx < len + 8) begin
      check_eq({req, " R6 lo_start"}, int'(lo_start_o), int'(!lvl && idx == 0));
      check_eq({req, " R6 hi_start"}, int'(hi_start_o), int'(lvl && idx == 0));
      check_eq({req, " R7 lo_mid"}, int'(lo_mid_o), int'(!lvl && idx == len / 2));
      check_eq({req, " R7 hi_mid"}, int'(hi_mid_o), int'(lvl && idx == len / 2));
      if (idx == wr_at) begin
        cfg_we = 1'b1;
        cfg_wdata = wr_val;
      end else begin
        cfg_we = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    wr_at = -1;
    check_eq({req, " phase length"}, idx, len);
  endtask

  task automatic stop_and_load(input logic [18:0] c);
    enable = 1'b0;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_gen();
    enable = 1'b1;
    @(negedge clk);
    check_eq("R5 scl low after enable", int'(scl_o), 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      check_eq("R1 scl idle", int'(scl_o), 1);
      check_eq("R1 strobes idle", int'({lo_start_o, hi_start_o, lo_mid_o, hi_mid_o}), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_symmetric();
    stop_and_load(mk_cfg(1, 3, 3));
    start_gen();
    watch_phase(1'b0, exp_len(3, 1), "R2 sym low");
    watch_phase(1'b1, exp_len(3, 1), "R3 sym high");
    watch_phase(1'b0, exp_len(3, 1), "R2 sym low2");
  endtask

  task automatic t_asym();
    stop_and_load(mk_cfg(0, 2, 5));
    start_gen();
    watch_phase(1'b0, exp_len(5, 0), "R2 asym low");
    watch_phase(1'b1, exp_len(2, 0), "R3 asym high");
  endtask

  task automatic t_clamp();
    stop_and_load(mk_cfg(7, 0, 1));
    start_gen();
    watch_phase(1'b0, exp_len(1, 7), "R4 clamp low");
    watch_phase(1'b1, OFFSET, "R10 zero high");
  endtask

  task automatic t_zero();
    stop_and_load(mk_cfg(3, 0, 0));
    start_gen();
    watch_phase(1'b0, OFFSET, "R10 zero low");
    watch_phase(1'b1, OFFSET, "R10 zero high");
  endtask

  task automatic t_midwrite();
    stop_and_load(mk_cfg(1, 2, 2));
    start_gen();
    wr_at = 1;
    wr_val = mk_cfg(0, 1, 6);
    watch_phase(1'b0, exp_len(2, 1), "R8 old low kept");
    watch_phase(1'b1, exp_len(1, 0), "R8 new high");
    watch_phase(1'b0, exp_len(6, 0), "R8 new low");
  endtask

  task automatic t_disable();
    stop_and_load(mk_cfg(0, 4, 4));
    start_gen();
    watch_phase(1'b0, exp_len(4, 0), "R9 pre low");
    @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check_eq("R9 scl released", int'(scl_o), 1);
      check_eq("R9 strobes off", int'({lo_start_o, hi_start_o, lo_mid_o, hi_mid_o}), 0);
      @(negedge clk);
    end
    start_gen();
    watch_phase(1'b0, exp_len(4, 0), "R9 restart low");
    watch_phase(1'b1, exp_len(4, 0), "R9 restart high");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_symmetric();
    t_asym();
    t_clamp();
    t_zero();
    t_midwrite();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule